// File: doc/BRIEF.md
# Vector Bit Permute Gather

This block picks sixteen single bits out of a 128-bit data vector and packs them into a small bitmask. A second 128-bit operand holds the selectors: each of its sixteen bytes is a bit position within the data vector. Positions are counted from the most significant end, so position 0 is the top bit of the data vector. A selector whose value is 128 or more does not wrap; it contributes a zero. The sixteen picked bits form the low 16 bits of a 128-bit result. All bits above them are zero.

An operation starts with a one-cycle valid strobe that carries both operands. The default build is an iterative engine. It resolves one selector per clock and holds a busy flag while it works. When the last selector is done it pulses the output valid for one cycle, and the result register keeps that value until the next completion. A parameter selects a flat build instead: sixteen selectors in parallel, with the result registered one cycle after the strobe.

Top module: `vbg_gather`

## Requirements
- R1: Selector k (k = 0..15) is bits [8k+7:8k] of `b_vec`, so byte 0 is the least significant byte. The bit it picks lands in `result` bit k.
- R2: A selector value s from 0 to 127 picks `a_vec` bit (127 - s) in LSB-0 numbering. Selector 0 therefore picks the most significant bit and selector 127 the least significant bit.
- R3: A selector value from 128 to 255 (its bit 7 set) yields 0 at its result position, whatever `a_vec` holds.
- R4: `result` bits 127 down to 16 are always zero.
- R5: An `in_valid` seen while `busy` is low starts an operation. `busy` is then high for exactly 16 cycles, and `out_valid` is a single-cycle pulse on the 16th rising edge after the accepting edge, with `busy` low in that cycle.
- R6: `in_valid` is ignored while `busy` is high. The operation in flight completes with its original operands and its original timing.
- R7: `result` changes only on the edge that raises `out_valid` and holds its value otherwise.
- R8: Reset (active-low, asynchronous) clears `busy`, `out_valid` and `result`.
- R9: An `in_valid` in the cycle that `out_valid` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Start strobe carrying both operands |
| a_vec | input | 128 | Data vector that bits are picked from |
| b_vec | input | 128 | Sixteen byte-wide bit selectors |
| busy | output | 1 | Engine is resolving selectors |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| result | output | 128 | Gathered bitmask in bits 15:0, zero above |

## Verification
Two things can happen in the same cycle: the completion pulse of one operation and the acceptance of the next start. The bench provokes this by holding `in_valid` high for a long stretch while it changes the operands every cycle. It also drives strobes in the middle of an operation, which must be ignored. A behavioural per-cycle model of busy, completion and the gathered value is compared with the outputs on every clock. A directed check confirms that `busy` rises right after the completion cycle while the result just delivered stays in place.

// File: rtl/vbg_pkg.sv
package vbg_pkg;
   typedef enum logic [0:0] {
      ENG_IDLE = 1'b0,
      ENG_RUN  = 1'b1
   } eng_state_t;
endpackage

// File: rtl/vbg_bit_pick.sv
module vbg_bit_pick #(
   parameter int DATA_W = 128,
   parameter int IDX_W  = 8
) (
   input  logic [DATA_W-1:0] vec,
   input  logic [IDX_W-1:0]  sel,
   output logic              bit_o
);
   localparam int PW = IDX_W + 1;
   localparam int SW = $clog2(DATA_W);

   logic [PW-1:0] sel_w;
   logic [PW-1:0] pos_w;
   logic          in_range;

   always_comb begin
      sel_w    = {1'b0, sel};
      in_range = (sel_w < PW'(DATA_W));
      pos_w    = PW'(DATA_W - 1) - sel_w;
      bit_o    = in_range ? vec[pos_w[SW-1:0]] : 1'b0;
   end
endmodule

// File: rtl/vbg_iter_engine.sv
module vbg_iter_engine
   import vbg_pkg::*;
#(
   parameter int DATA_W  = 128,
   parameter int IDX_W   = 8,
   parameter int NUM_IDX = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [DATA_W-1:0]  a_in,
   input  logic [DATA_W-1:0]  b_in,
   output logic               busy,
   output logic               done,
   output logic [NUM_IDX-1:0] gathered
);
   localparam int CW  = (NUM_IDX > 1) ? $clog2(NUM_IDX) : 1;
   localparam int SLW = NUM_IDX * IDX_W;

   eng_state_t         state;
   logic [DATA_W-1:0]  a_q;
   logic [SLW-1:0]     sel_q;
   logic [NUM_IDX-1:0] acc;
   logic [CW-1:0]      cnt;
   logic               pick;

   vbg_bit_pick #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_pick (
      .vec   (a_q),
      .sel   (sel_q[IDX_W-1:0]),
      .bit_o (pick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ENG_IDLE;
         a_q      <= '0;
         sel_q    <= '0;
         acc      <= '0;
         cnt      <= '0;
         done     <= 1'b0;
         gathered <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ENG_IDLE: begin
               if (start) begin
                  a_q   <= a_in;
                  sel_q <= b_in[SLW-1:0];
                  acc   <= '0;
                  cnt   <= '0;
                  state <= ENG_RUN;
               end
            end
            ENG_RUN: begin
               acc   <= {pick, acc[NUM_IDX-1:1]};
               sel_q <= sel_q >> IDX_W;
               cnt   <= cnt + 1'b1;
               if (cnt == CW'(NUM_IDX - 1)) begin
                  gathered <= {pick, acc[NUM_IDX-1:1]};
                  done     <= 1'b1;
                  state    <= ENG_IDLE;
               end
            end
            default: state <= ENG_IDLE;
         endcase
      end
   end

   assign busy = (state == ENG_RUN);
endmodule

// File: rtl/vbg_flat_engine.sv
module vbg_flat_engine #(
   parameter int DATA_W  = 128,
   parameter int IDX_W   = 8,
   parameter int NUM_IDX = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [DATA_W-1:0]  a_in,
   input  logic [DATA_W-1:0]  b_in,
   output logic               done,
   output logic [NUM_IDX-1:0] gathered
);
   logic [NUM_IDX-1:0] picks;

   for (genvar k = 0; k < NUM_IDX; k++) begin : g_lane
      vbg_bit_pick #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_pick (
         .vec   (a_in),
         .sel   (b_in[k*IDX_W +: IDX_W]),
         .bit_o (picks[k])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done     <= 1'b0;
         gathered <= '0;
      end else begin
         done <= start;
         if (start) gathered <= picks;
      end
   end
endmodule

// File: rtl/vbg_gather.sv
module vbg_gather #(
   parameter int DATA_W    = 128,
   parameter int IDX_W     = 8,
   parameter int NUM_IDX   = 16,
   parameter int RES_W     = 128,
   parameter bit ITERATIVE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] a_vec,
   input  logic [DATA_W-1:0] b_vec,
   output logic              busy,
   output logic              out_valid,
   output logic [RES_W-1:0]  result
);
   if ((DATA_W & (DATA_W - 1)) != 0) begin : g_chk_pow2
      $error("DATA_W must be a power of two");
   end
   if (DATA_W > (1 << IDX_W)) begin : g_chk_idx
      $error("IDX_W too narrow to address DATA_W");
   end
   if (NUM_IDX * IDX_W > DATA_W) begin : g_chk_sel
      $error("selectors do not fit in b_vec");
   end
   if (NUM_IDX < 2 || NUM_IDX > RES_W) begin : g_chk_res
      $error("NUM_IDX out of range");
   end

   logic [NUM_IDX-1:0] gathered;
   logic               eng_done;
   logic               eng_busy;

   if (ITERATIVE) begin : g_iter
      vbg_iter_engine #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_IDX(NUM_IDX)) u_eng (
         .clk      (clk),
         .rst_n    (rst_n),
         .start    (in_valid),
         .a_in     (a_vec),
         .b_in     (b_vec),
         .busy     (eng_busy),
         .done     (eng_done),
         .gathered (gathered)
      );
   end else begin : g_flat
      vbg_flat_engine #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_IDX(NUM_IDX)) u_eng (
         .clk      (clk),
         .rst_n    (rst_n),
         .start    (in_valid),
         .a_in     (a_vec),
         .b_in     (b_vec),
         .done     (eng_done),
         .gathered (gathered)
      );
      assign eng_busy = 1'b0;
   end

   assign busy      = eng_busy;
   assign out_valid = eng_done;
   assign result    = RES_W'(gathered);
endmodule

// File: rtl/vbg_gather_chk.sv
module vbg_gather_chk #(
   parameter bit ITERATIVE = 1'b1,
   parameter int RES_W     = 128
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             busy,
   input logic             out_valid,
   input logic [RES_W-1:0] result
);
   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> (!busy && !out_valid && result == '0)); // R8

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(result)); // R7

   if (ITERATIVE) begin : g_iter_props
      AST_BUSY_EXCLUDES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
         busy |-> !out_valid); // R5

      AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |=> !out_valid); // R5

      AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !busy) |=> busy); // R9

      AST_NO_DONE_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         (!busy && !in_valid) |=> !busy); // R6
   end
endmodule

bind vbg_gather vbg_gather_chk #(.ITERATIVE(ITERATIVE), .RES_W(RES_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .busy      (busy),
   .out_valid (out_valid),
   .result    (result)
);

// File: tb/vbg_gather_test.sv
`timescale 1ns/1ps
module vbg_gather_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [127:0] a_vec = '0;
   logic [127:0] b_vec = '0;
   logic         busy;
   logic         out_valid;
   logic [127:0] result;

   int checks = 0;
   int bad    = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   vbg_gather uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .a_vec(a_vec), .b_vec(b_vec),
      .busy(busy), .out_valid(out_valid), .result(result)
   );

   function automatic logic [127:0] ref_gather(input logic [127:0] a, input logic [127:0] b);
      logic [127:0] r;
      r = '0;
      for (int k = 0; k < 16; k++) begin
         int s;
         s = int'(b[8*k +: 8]);
         if (s < 128) r[k] = a[127 - s];
      end
      return r;
   endfunction

   // behavioural per-cycle reference
   bit           m_busy = 0;
   bit           m_ov   = 0;
   int           m_cnt  = 0;
   logic [127:0] m_res  = '0;
   logic [127:0] m_a, m_b;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy = 0; m_ov = 0; m_cnt = 0; m_res = '0;
      end else begin
         m_ov = 0;
         if (m_busy) begin
            m_cnt++;
            if (m_cnt == 16) begin
               m_busy = 0; m_ov = 1; m_res = ref_gather(m_a, m_b);
            end
         end else if (in_valid) begin
            m_busy = 1; m_cnt = 0; m_a = a_vec; m_b = b_vec;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // compare model every clock, away from the edge
   always @(negedge clk) if (rst_n && !finished) begin
      chk(busy == m_busy, "R5/R6 busy", 128'(busy), 128'(m_busy));
      chk(out_valid == m_ov, "R5/R9 out_valid", 128'(out_valid), 128'(m_ov));
      chk(result == m_res, "R1/R2/R3/R7 result", result, m_res);
      chk(result[127:16] == '0, "R4 upper zero", result, m_res);
   end

   task automatic run_op(input logic [127:0] a, input logic [127:0] b,
                         input logic [127:0] exp, input string tag);
      @(negedge clk);
      in_valid = 1; a_vec = a; b_vec = b;
      @(negedge clk);
      in_valid = 0;
      while (!out_valid) @(negedge clk);
      chk(result == exp, tag, result, exp);
   endtask

   function automatic logic [127:0] fill(input logic [7:0] v);
      logic [127:0] r;
      for (int k = 0; k < 16; k++) r[8*k +: 8] = v;
      return r;
   endfunction

   initial begin
      #400000;
      if (!finished) begin
         bad++;
         $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      logic [127:0] ra, rb, first_exp, hold;
      repeat (3) @(negedge clk);
      chk(busy == 0 && out_valid == 0 && result == '0, "R8 reset state", result, '0);
      rst_n = 1;
      @(negedge clk);

      // R2: selector 0 picks MSB, 127 picks LSB
      run_op(128'h1 << 127, fill(8'd0), 128'hFFFF, "R2 index0");
      run_op(128'h1, fill(8'd127), 128'hFFFF, "R2 index127");
      run_op(~(128'h1 << 127), fill(8'd0), 128'h0, "R2 index0 neg");
      // R3: out-of-range selectors give zero
      run_op({128{1'b1}}, fill(8'd128), 128'h0, "R3 index128");
      run_op({128{1'b1}}, fill(8'd255), 128'h0, "R3 index255");
      // R1: byte order to result bit order
      run_op({128{1'b1}}, {8{8'd128, 8'd0}}, 128'h5555, "R1 byte order");
      run_op(128'h1 << 127, {8'd0, {15{8'd200}}}, 128'h8000, "R1 top byte");

      // R6: strobes during busy are ignored
      ra = 128'hDEADBEEF_01234567_89ABCDEF_F0E1D2C3;
      rb = 128'h00_7F_10_20_30_40_50_60_70_01_02_03_80_FF_05_06;
      first_exp = ref_gather(ra, rb);
      @(negedge clk);
      in_valid = 1; a_vec = ra; b_vec = rb;
      @(negedge clk);
      a_vec = ~ra; b_vec = ~rb;
      repeat (5) @(negedge clk);
      in_valid = 0;
      while (!out_valid) @(negedge clk);
      chk(result == first_exp, "R6 ignored start", result, first_exp);

      // random vectors
      for (int n = 0; n < 24; n++) begin
         ra = {$urandom, $urandom, $urandom, $urandom};
         rb = {$urandom, $urandom, $urandom, $urandom};
         if (n % 2 == 0) rb = rb & fill(8'h7F);
         run_op(ra, rb, ref_gather(ra, rb), "R1/R2/R3 random");
      end

      // R9: continuous strobe, completion and new start collide
      @(negedge clk);
      in_valid = 1;
      for (int c = 0; c < 60; c++) begin
         a_vec = {$urandom, $urandom, $urandom, $urandom};
         b_vec = {$urandom, $urandom, $urandom, $urandom};
         if (out_valid) begin
            hold = result;
            @(negedge clk);
            chk(busy == 1, "R9 back-to-back start", 128'(busy), 128'd1);
            chk(result == hold, "R7 result held", result, hold);
         end else begin
            @(negedge clk);
         end
      end
      in_valid = 0;
      repeat (20) @(negedge clk);

      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule